// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter with Strobe Decode

This block sits beside an 8-bit-era processor whose low address byte and data byte share one set of pins. Early in each machine cycle the processor drives the low address byte on the shared bus and pulses an address latch enable. A little later the same pins carry the data byte. The block keeps the low address byte in a latch, so that a full 16-bit address is available for the rest of the cycle. The upper address byte, which has its own pins, passes straight through. The shared bus is also offered as a separate data path.

The processor's active-low read and write strobes are combined with its memory/IO select. From them the block forms four separate active-low strobes: memory read, memory write, IO read and IO write. Memory devices and peripherals can each be wired to their own strobe without extra glue logic.

The reset input is asynchronous and active low. Its release is synchronised to the clock.

Top module: `bus_demux`

## Requirements
- R1: While reset is active, the low address output `addr_out[7:0]` reads 00h, all four strobes are high and `data_valid` is 0, whatever the processor inputs are.
- R2: While `ale` is 1 (and reset is not active), `addr_out[7:0]` equals `ad_bus` in the same cycle (transparent).
- R3: The latch captures `ad_bus` at every rising clock edge where `ale` is 1. While `ale` is 0, `addr_out[7:0]` holds the value captured at the last such edge, even while `ad_bus` changes.
- R4: `addr_out[15:8]` always equals `addr_hi` combinationally.
- R5: When `rd_n`=0, `wr_n`=1 and `io_sel`=0, only `mem_rd_n` is 0.
- R6: When `rd_n`=0, `wr_n`=1 and `io_sel`=1, only `io_rd_n` is 0.
- R7: When `wr_n`=0, `rd_n`=1 and `io_sel`=0, only `mem_wr_n` is 0.
- R8: When `wr_n`=0, `rd_n`=1 and `io_sel`=1, only `io_wr_n` is 0.
- R9: When `rd_n` and `wr_n` are both 1, or both 0, all four strobes are 1. At most one strobe is ever 0.
- R10: `data_out` always equals `ad_bus`. `data_valid` is 1 exactly when `ale` is 0, reset is not active and one strobe is 0.
- R11: After `rst_n` rises, the block stays in reset until the second rising clock edge. The strobes stay high after the first edge and follow their inputs after the second.
- R12: An opcode fetch works end to end. Address 2005h is driven with `ale` high in T1, then 4Fh is driven with a memory read in T2 and T3. During T2 and T3 the block shows address 2005h, data 4Fh, `data_valid` 1 and only `mem_rd_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ale | input | 1 | Address latch enable (high: low address byte is on the shared bus) |
| ad_bus | input | 8 | Shared low-address/data bus |
| addr_hi | input | 8 | Upper address byte |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| io_sel | input | 1 | Access select: 0 memory, 1 IO |
| addr_out | output | 16 | Recovered full address |
| data_out | output | 8 | Data path (shared bus) |
| data_valid | output | 1 | Data phase qualifier |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | IO read strobe, active low |
| io_wr_n | output | 1 | IO write strobe, active low |

## Verification
The only internal state is the captured low address byte and the reset synchroniser. A wrong captured byte shows at `addr_out[7:0]` in the first cycle after `ale` falls, because the latch is no longer transparent from then on. A faulty synchroniser shows up as strobes that respond one edge too early or too late after reset is released. The strobe decode has no state, so the bench sweeps every combination of `ale`, `rd_n`, `wr_n` and `io_sel` and checks it in the same cycle. It also sweeps many address bytes through a latch-then-hold sequence.

// File: rtl/bus_demux_pkg.sv
package bus_demux_pkg;

  // Four separate active-low strobes produced by the decoder
  typedef struct packed {
    logic mem_rd_n;
    logic mem_wr_n;
    logic io_rd_n;
    logic io_wr_n;
  } strobes_t;

  localparam strobes_t STROBES_IDLE = '{mem_rd_n: 1'b1, mem_wr_n: 1'b1,
                                        io_rd_n: 1'b1, io_wr_n: 1'b1};

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/bdx_rst_sync.sv
module bdx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign run_n = chain_q[STAGES-1];

  // R11: the internal reset is released only on a clock edge, never while the pin is low
  assert_release_clocked_R11: assert property (@(posedge clk)
    !rst_n |-> !run_n);
endmodule

// File: rtl/bdx_addr_latch.sv
module bdx_addr_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         run_n,
  input  logic         ale,
  input  logic [W-1:0] bus,
  output logic [W-1:0] lo
);
  logic         cap_en;
  logic [W-1:0] hold_d;
  logic [W-1:0] hold_q;

  // next state: the latch loads on every edge while ale is high
  always_comb begin
    cap_en = ale;
    hold_d = hold_q;
    if (cap_en) hold_d = bus;
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  // transparent while ale is high, held value otherwise
  always_comb begin
    if (!run_n)   lo = '0;
    else if (ale) lo = bus;
    else          lo = hold_q;
  end

  // R3: with ale low across two edges, the low address cannot move
  assert_lo_held_R3: assert property (@(posedge clk) disable iff (!run_n)
    (!ale && $past(!ale) && $past(run_n)) |-> $stable(lo));

  // R3: the byte on the bus during an ale edge is what is kept afterwards
  assert_capture_R3: assert property (@(posedge clk) disable iff (!run_n)
    (ale ##1 !ale) |-> (lo == $past(bus)));

  // R1: reset forces the low address to zero
  always_comb begin
    if (!run_n) assert_lo_reset_R1: assert (lo == '0);
  end
endmodule

// File: rtl/bdx_strobe_dec.sv
module bdx_strobe_dec
  import bus_demux_pkg::*;
(
  input  logic     clk,
  input  logic     run_n,
  input  logic     rd_n,
  input  logic     wr_n,
  input  logic     io_sel,
  output strobes_t strb
);
  acc_kind_e kind;

  // only a clean read or a clean write produces a strobe
  always_comb begin
    unique case ({rd_n, wr_n})
      2'b01:   kind = ACC_READ;
      2'b10:   kind = ACC_WRITE;
      default: kind = ACC_NONE;
    endcase
    if (!run_n) kind = ACC_NONE;
  end

  always_comb begin
    strb = STROBES_IDLE;
    case (kind)
      ACC_READ: begin
        if (io_sel) strb.io_rd_n  = 1'b0;
        else        strb.mem_rd_n = 1'b0;
      end
      ACC_WRITE: begin
        if (io_sel) strb.io_wr_n  = 1'b0;
        else        strb.mem_wr_n = 1'b0;
      end
      default: strb = STROBES_IDLE;
    endcase
  end

  // R9: at most one strobe low at any time
  assert_one_strobe_R9: assert property (@(posedge clk)
    $countones(~strb) <= 1);

  // R5: memory read only for read, not write, memory space
  assert_mem_rd_R5: assert property (@(posedge clk) disable iff (!run_n)
    !strb.mem_rd_n |-> (!rd_n && wr_n && !io_sel));

  // R6: IO read only in IO space
  assert_io_rd_R6: assert property (@(posedge clk) disable iff (!run_n)
    !strb.io_rd_n |-> (!rd_n && wr_n && io_sel));

  // R7: memory write only for write in memory space
  assert_mem_wr_R7: assert property (@(posedge clk) disable iff (!run_n)
    !strb.mem_wr_n |-> (!wr_n && rd_n && !io_sel));

  // R8: IO write only for write in IO space
  assert_io_wr_R8: assert property (@(posedge clk) disable iff (!run_n)
    !strb.io_wr_n |-> (!wr_n && rd_n && io_sel));

  // R1: reset keeps every strobe inactive
  always_comb begin
    if (!run_n) assert_strobe_reset_R1: assert (strb == STROBES_IDLE);
  end
endmodule

// File: rtl/bus_demux.sv
module bus_demux
  import bus_demux_pkg::*;
#(
  parameter int LO_W   = 8,
  parameter int HI_W   = 8,
  parameter int SYNC_N = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ale,
  input  logic [LO_W-1:0]      ad_bus,
  input  logic [HI_W-1:0]      addr_hi,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic                 io_sel,
  output logic [HI_W+LO_W-1:0] addr_out,
  output logic [LO_W-1:0]      data_out,
  output logic                 data_valid,
  output logic                 mem_rd_n,
  output logic                 mem_wr_n,
  output logic                 io_rd_n,
  output logic                 io_wr_n
);
  localparam int ADDR_W = HI_W + LO_W;

  logic            run_n;
  logic [LO_W-1:0] lo_addr;
  strobes_t        strb;
  logic            any_strobe;

  bdx_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  bdx_addr_latch #(.W(LO_W)) u_latch (
    .clk   (clk),
    .run_n (run_n),
    .ale   (ale),
    .bus   (ad_bus),
    .lo    (lo_addr)
  );

  bdx_strobe_dec u_dec (
    .clk    (clk),
    .run_n  (run_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .io_sel (io_sel),
    .strb   (strb)
  );

  always_comb begin
    any_strobe = ~&strb;
    addr_out   = {addr_hi, lo_addr};
    data_out   = ad_bus;
    data_valid = run_n && !ale && any_strobe;
    mem_rd_n   = strb.mem_rd_n;
    mem_wr_n   = strb.mem_wr_n;
    io_rd_n    = strb.io_rd_n;
    io_wr_n    = strb.io_wr_n;
  end

  // R10: the data qualifier is never raised during the address phase
  assert_valid_no_ale_R10: assert property (@(posedge clk)
    data_valid |-> (!ale && (!mem_rd_n || !mem_wr_n || !io_rd_n || !io_wr_n)));

  // R4: upper address pass-through
  assert_hi_pass_R4: assert property (@(posedge clk)
    addr_out[ADDR_W-1:LO_W] == addr_hi);
endmodule

// File: tb/bus_demux_test.sv
`timescale 1ns/1ps
module bus_demux_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ale;
  logic [7:0]  ad_bus;
  logic [7:0]  addr_hi;
  logic        rd_n, wr_n, io_sel;
  logic [15:0] addr_out;
  logic [7:0]  data_out;
  logic        data_valid, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bus_demux uut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_bus(ad_bus), .addr_hi(addr_hi),
    .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel), .addr_out(addr_out),
    .data_out(data_out), .data_valid(data_valid), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // wait for the next edge, then move a little past it to drive
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [3:0] exp_strb(input logic r, input logic w, input logic s, input logic act);
    // order {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}
    logic [3:0] e = 4'b1111;
    if (act && !r && w) e = s ? 4'b1101 : 4'b0111;
    if (act && r && !w) e = s ? 4'b1110 : 4'b1011;
    return e;
  endfunction

  initial begin
    rst_n = 1'b0; ale = 1'b1; ad_bus = 8'hAA; addr_hi = 8'h12;
    rd_n = 1'b0; wr_n = 1'b1; io_sel = 1'b0;
    #25;
    // R1: reset state with active-looking inputs
    chk("R1 lo addr", {16'h0, addr_out}, {16'h0, 16'h1200});
    chk("R1 strobes", {28'h0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 32'hF);
    chk("R1 valid", {31'h0, data_valid}, 32'h0);
    // R11: release between edges
    #3 rst_n = 1'b1;
    ale = 1'b0;
    @(posedge clk); #5;
    chk("R11 after 1 edge", {28'h0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 32'hF);
    @(posedge clk); #5;
    chk("R11 after 2 edges", {28'h0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 32'h7);
    rd_n = 1'b1;

    // R12: opcode fetch, T1..T3
    tick();
    addr_hi = 8'h20; ad_bus = 8'h05; ale = 1'b1; io_sel = 1'b0;
    #10;
    chk("R2 T1 transparent", {16'h0, addr_out}, 32'h2005);
    tick();
    ale = 1'b0; ad_bus = 8'h4F; rd_n = 1'b0;
    for (int t = 2; t <= 3; t++) begin
      #10;
      chk("R12 addr", {16'h0, addr_out}, 32'h2005);
      chk("R12 data", {24'h0, data_out}, 32'h4F);
      chk("R12 valid", {31'h0, data_valid}, 32'h1);
      chk("R12 only mem rd", {28'h0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 32'h7);
      tick();
    end
    rd_n = 1'b1;

    // R2 R3 R4: address sweep, latch then hold while the bus moves
    for (int a = 0; a < 256; a += 7) begin
      addr_hi = 8'(a * 3); ad_bus = 8'(a); ale = 1'b1;
      #10;
      chk("R2 follow", {24'h0, addr_out[7:0]}, a);
      chk("R4 hi", {24'h0, addr_out[15:8]}, (a * 3) % 256);
      tick();
      ale = 1'b0; ad_bus = 8'(~a);
      #10;
      chk("R3 hold", {24'h0, addr_out[7:0]}, a);
      tick();
      ad_bus = 8'(a + 1);
      #10;
      chk("R3 hold 2", {24'h0, addr_out[7:0]}, a);
      chk("R10 data follows bus", {24'h0, data_out}, (a + 1) % 256);
      tick();
    end

    // R5..R10: exhaustive control sweep
    for (int v = 0; v < 16; v++) begin
      ale = v[3]; rd_n = v[2]; wr_n = v[1]; io_sel = v[0];
      #10;
      chk($sformatf("R5 R6 R7 R8 R9 strobes v=%0d", v),
          {28'h0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
          {28'h0, exp_strb(v[2], v[1], v[0], 1'b1)});
      chk($sformatf("R10 valid v=%0d", v), {31'h0, data_valid},
          {31'h0, (!v[3] && (v[2] != v[1]))});
      tick();
    end

    // R1: asynchronous assertion mid-cycle
    ale = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
    #3 rst_n = 1'b0;
    #2;
    chk("R1 async strobes", {28'h0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 32'hF);
    chk("R1 async lo", {24'h0, addr_out[7:0]}, 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule